// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Occupancy Count

This block is a single-clock first-in first-out queue of `DATA_W`-bit words. A write strobe stores the input word at the tail. A read strobe retires the word at the head. The storage is a plain array with no reset, written through one port and read through another, so synthesis can map it onto dual-port RAM. The block reports an occupancy count and registered empty and full flags. It also keeps two sticky error flags: one for writes refused while full, one for reads refused while empty.

A parameter chosen at elaboration picks one of two read styles:

- **Classic.** A read request loads the head word into an output register one cycle later. That register holds its value until the next accepted read.
- **Look-ahead.** The head word is driven onto the output as soon as it is stored, with no request needed. In this style the queue has room for three words more than the nominal depth.

When a read and a write arrive in the same cycle, the read is applied first. A full queue can therefore take a write in the same cycle it gives up a word. A synchronous local clear empties the queue and zeroes the count and flags. It does not touch the stored words or the classic output register.

Top module: `dmfifo_top`

## Requirements
- R1: After the global reset, empty is 1, full is 0, count is 0, both sticky flags are 0 and the classic data output is 0.
- R2: A write strobe sampled high and accepted at a clock edge raises count by one and clears empty, both visible right after that edge.
- R3: Words leave in the order they were written. In classic mode, an accepted read loads the head word onto the output after that edge, and the output keeps that value until the next accepted read.
- R4: In classic mode (`FWFT`=0) the capacity is `DEPTH`, and full is 1 exactly when count equals `DEPTH`.
- R5: In look-ahead mode (`FWFT`=1) the capacity is `DEPTH`+3, and full is 1 exactly when count equals `DEPTH`+3.
- R6: In look-ahead mode, whenever count is non-zero the data output shows the oldest stored word without any read request. This includes the cycle in which empty first falls.
- R7: A read and a write in the same cycle are ordered read first, then write. On a full queue both are accepted and count is unchanged. On an empty queue the read is refused and the write is accepted, giving count 1.
- R8: A write while full with no read is dropped. Count and stored contents do not change, and the sticky overflow flag is set until a reset.
- R9: A read while empty is ignored. Count stays 0, the classic output keeps its value, and the sticky underflow flag is set until a reset.
- R10: Local clear, sampled high, empties the queue. After that edge count is 0, empty is 1, full is 0 and both sticky flags are 0. The classic data output keeps its value.
- R11: Empty is 1 exactly when count is 0. Count never exceeds the capacity of the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low global reset |
| localRst | input | 1 | Synchronous clear of count, flags and pointers |
| push | input | 1 | Write strobe |
| pop | input | 1 | Read strobe |
| din | input | DATA_W | Word to store |
| dout | output | DATA_W | Head word: registered in classic mode, looked-ahead in look-ahead mode |
| empty | output | 1 | Queue holds no words |
| full | output | 1 | Queue holds its capacity |
| count | output | $clog2(DEPTH+4) | Number of words stored |
| overflow | output | 1 | Sticky: a write was refused |
| underflow | output | 1 | Sticky: a read was refused |

## Verification
The hardest states to reach are at the capacity limits. One is a simultaneous read and write on a full queue, where both must be accepted. Another is the band of three extra look-ahead slots, where a classic queue would already refuse writes. The bench drives one input stream into a classic instance and a look-ahead instance side by side. As a result, the same writes overflow the first while they still fill the second. It then holds both strobes high at full and at empty. A long phase follows in which writes and reads are weighted in alternating windows, so the queues swing repeatedly between empty and full with occasional local clears. Every cycle is compared against queue models kept in the bench.

// File: rtl/fifoPkg.sv
package fifoPkg;
  // Per-cycle commands from the control path to the storage path
  typedef struct packed {
    logic wrEn;    // store din at the write pointer, advance it
    logic rdEn;    // retire the head word, advance the read pointer
    logic clrPtr;  // return both pointers to slot 0
  } fifoStrobes_t;

  function automatic int fifoCapacity(input int depth, input bit fwft);
    return fwft ? depth + 3 : depth;
  endfunction
endpackage

// File: rtl/fifoCtrl.sv
module fifoCtrl
  import fifoPkg::*;
#(
  parameter int DEPTH = 10,
  parameter bit FWFT  = 1'b0,
  localparam int CAP   = fifoCapacity(DEPTH, FWFT),
  localparam int CNT_W = $clog2(DEPTH + 4)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             localRst,
  input  logic             push,
  input  logic             pop,
  output fifoStrobes_t     strobes,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full,
  output logic             overflow,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] CAP_CNT = CNT_W'(CAP);

  logic             popOk;
  logic             pushOk;
  logic [CNT_W-1:0] cntNext;

  // Read is resolved first; a read on a full queue frees the slot a write needs
  always_comb begin
    popOk   = pop && (count != '0);
    pushOk  = push && ((count != CAP_CNT) || popOk);
    cntNext = count + CNT_W'(pushOk) - CNT_W'(popOk);
    strobes.clrPtr = localRst;
    strobes.rdEn   = popOk && !localRst;
    strobes.wrEn   = pushOk && !localRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      empty     <= 1'b1;
      full      <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else if (localRst) begin
      count     <= '0;
      empty     <= 1'b1;
      full      <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      count <= cntNext;
      empty <= (cntNext == '0);
      full  <= (cntNext == CAP_CNT);
      if (push && !pushOk) overflow  <= 1'b1;
      if (pop && !popOk)   underflow <= 1'b1;
    end
  end

  // R2
  push_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !localRst && !full) |=> (count == $past(count) + CNT_W'(1)) && !empty);
  // R8
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !localRst && full) |=> $stable(count) && overflow);
  // R9
  unf_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && !localRst && empty) |=> (count == '0) && underflow);
  // R7
  both_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop && full && !localRst) |=> $stable(count) && full);
  // R7
  both_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop && empty && !localRst) |=> (count == CNT_W'(1)) && underflow);
  // R10
  lrst_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    localRst |=> (count == '0) && empty && !full && !overflow && !underflow);
  // R11
  empty_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty == (count == '0));
  // R4
  full_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    full == (count == CAP_CNT));
  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CAP_CNT);
endmodule

// File: rtl/fifoDatapath.sv
module fifoDatapath
  import fifoPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 10,
  parameter bit FWFT   = 1'b0,
  localparam int CAP   = fifoCapacity(DEPTH, FWFT),
  localparam int PTR_W = $clog2(CAP)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(CAP - 1);

  // No reset on the array so it can map to RAM
  logic [DATA_W-1:0] mem [CAP];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.wrEn) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobes.clrPtr) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.wrEn) wrPtr <= bumpPtr(wrPtr);
      if (strobes.rdEn) rdPtr <= bumpPtr(rdPtr);
    end
  end

  generate
    if (FWFT) begin : g_lookAhead
      // Head word driven straight from the array
      assign dout = mem[rdPtr];
    end else begin : g_classic
      logic [DATA_W-1:0] doutQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             doutQ <= '0;
        else if (strobes.rdEn) doutQ <= mem[rdPtr];
      end
      assign dout = doutQ;

      // R3
      dout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.rdEn |=> $stable(dout));
    end
  endgenerate

  // R11
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr <= LAST_SLOT) && (rdPtr <= LAST_SLOT));
  // R10
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrPtr |=> (wrPtr == '0) && (rdPtr == '0));
endmodule

// File: rtl/dmfifo_top.sv
module dmfifo_top
  import fifoPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 10,
  parameter bit FWFT   = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          localRst,
  input  logic                          push,
  input  logic                          pop,
  input  logic [DATA_W-1:0]             din,
  output logic [DATA_W-1:0]             dout,
  output logic                          empty,
  output logic                          full,
  output logic [$clog2(DEPTH+4)-1:0]    count,
  output logic                          overflow,
  output logic                          underflow
);
  fifoStrobes_t strobes;

  initial begin
    if (DEPTH < 4) $error("DEPTH must be at least 4");
  end

  fifoCtrl #(.DEPTH(DEPTH), .FWFT(FWFT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .localRst  (localRst),
    .push      (push),
    .pop       (pop),
    .strobes   (strobes),
    .count     (count),
    .empty     (empty),
    .full      (full),
    .overflow  (overflow),
    .underflow (underflow)
  );

  fifoDatapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FWFT(FWFT)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .din     (din),
    .dout    (dout)
  );
endmodule

// File: tb/dmfifo_top_tb.sv
module dmfifo_top_tb;
  localparam int DW    = 8;
  localparam int DEP   = 4;
  localparam int CW    = $clog2(DEP + 4);
  localparam int CAP_C = DEP;
  localparam int CAP_F = DEP + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic localRst = 1'b0, push = 1'b0, pop = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] doutC, doutF;
  logic emptyC, fullC, ovfC, unfC, emptyF, fullF, ovfF, unfF;
  logic [CW-1:0] cntC, cntF;

  always #2.5 clk = ~clk;  // 200 MHz

  dmfifo_top #(.DATA_W(DW), .DEPTH(DEP), .FWFT(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .localRst(localRst), .push(push), .pop(pop), .din(din),
    .dout(doutC), .empty(emptyC), .full(fullC), .count(cntC),
    .overflow(ovfC), .underflow(unfC));

  dmfifo_top #(.DATA_W(DW), .DEPTH(DEP), .FWFT(1'b1)) u_dutFwft (
    .clk(clk), .rstN(rstN), .localRst(localRst), .push(push), .pop(pop), .din(din),
    .dout(doutF), .empty(emptyF), .full(fullF), .count(cntF),
    .overflow(ovfF), .underflow(unfF));

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Reference queues
  int qC[$];
  int qF[$];
  logic ovC = 1'b0, unC = 1'b0, ovF = 1'b0, unF = 1'b0;
  int   expDoutC = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic modelApply(ref int q[$], input int cap, ref logic ov, ref logic un,
                            input bit isClassic, input logic ps, pp, lr, input int d);
    bit popOk;
    if (lr) begin
      q.delete();
      ov = 1'b0;
      un = 1'b0;
    end else begin
      popOk = pp && (q.size() > 0);
      if (popOk) begin
        if (isClassic) expDoutC = q.pop_front();
        else void'(q.pop_front());
      end else if (pp) un = 1'b1;
      if (ps) begin
        if (q.size() < cap) q.push_back(d);
        else ov = 1'b1;
      end
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "classic count", int'(cntC), qC.size());
    chk(tag, "classic empty", int'(emptyC), int'(qC.size() == 0));
    chk(tag, "classic full", int'(fullC), int'(qC.size() == CAP_C));
    chk(tag, "classic overflow", int'(ovfC), int'(ovC));
    chk(tag, "classic underflow", int'(unfC), int'(unC));
    chk(tag, "classic dout", int'(doutC), expDoutC);
    chk(tag, "lookahead count", int'(cntF), qF.size());
    chk(tag, "lookahead empty", int'(emptyF), int'(qF.size() == 0));
    chk(tag, "lookahead full", int'(fullF), int'(qF.size() == CAP_F));
    chk(tag, "lookahead overflow", int'(ovfF), int'(ovF));
    chk(tag, "lookahead underflow", int'(unfF), int'(unF));
    if (qF.size() > 0) chk(tag, "lookahead dout", int'(doutF), qF[0]);
  endtask

  // Inputs driven at the falling edge; outputs compared at the following falling edge
  task automatic step(input logic ps, input logic pp, input logic lr, input int d,
                      input string tag);
    push = ps; pop = pp; localRst = lr; din = DW'(d);
    @(posedge clk);
    @(negedge clk);
    modelApply(qC, CAP_C, ovC, unC, 1'b1, ps, pp, lr, d);
    modelApply(qF, CAP_F, ovF, unF, 1'b0, ps, pp, lr, d);
    compareAll(tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    // First word: count, empty, and look-ahead head in the same cycle
    step(1, 0, 0, 8'h11, "R2");
    chk("R6", "lookahead head", int'(doutF), 8'h11);
    for (int i = 1; i < DEP; i++) step(1, 0, 0, 8'h11 + i, "R2");
    chk("R4", "classic full at depth", int'(fullC), 1);
    chk("R5", "lookahead not full at depth", int'(fullF), 0);
    // Three more: classic overflows, look-ahead fills its extra slots
    for (int i = 0; i < 3; i++) step(1, 0, 0, 8'h51 + i, "R8");
    chk("R5", "lookahead full at depth+3", int'(fullF), 1);
    step(1, 0, 0, 8'hEE, "R8");
    // Full: read and write together
    step(1, 1, 0, 8'h77, "R7");
    step(1, 1, 0, 8'h78, "R7");
    // Drain in order, then read from empty
    for (int i = 0; i < CAP_F + 1; i++) step(0, 1, 0, 0, "R3");
    step(0, 1, 0, 0, "R9");
    chk("R9", "classic dout held on empty read", int'(doutC), expDoutC);
    // Empty: read and write together
    step(1, 1, 0, 8'h3C, "R7");
    step(1, 0, 0, 8'h3D, "R2");
    step(0, 1, 0, 0, "R3");
    // Local clear
    step(0, 0, 1, 0, "R10");
    chk("R10", "classic dout kept over clear", int'(doutC), 8'h3C);
    step(0, 1, 0, 0, "R9");
    step(0, 0, 1, 0, "R10");

    // Weighted sweep: alternating write-heavy and read-heavy windows
    for (int i = 0; i < 3000; i++) begin
      bit heavyW;
      logic ps, pp, lr;
      heavyW = ((i / 40) % 2) == 0;
      ps = heavyW ? (($urandom % 4) != 0) : (($urandom % 4) == 0);
      pp = heavyW ? (($urandom % 4) == 0) : (($urandom % 4) != 0);
      lr = (($urandom % 211) == 0);
      step(ps, pp, lr, int'($urandom % 256), "R3");
      if (qC.size() == CAP_C) chk("R11", "classic at cap", int'(cntC), CAP_C);
    end
    finishRun();
  end
endmodule